// File: doc/BRIEF.md
# Gate-Driver Fault Supervisor

This block sits between the switching command of one half-bridge and its two gate drivers. It watches digitised comparator flags (driver supply ready, driver supply undervoltage, bootstrap supply undervoltage, switch node at the upper rail, switch node at ground) together with the switching command and the enable line. From these it decides, every clock cycle, whether the high-side gate and the low-side gate may be driven. It also reports a global force-off and a fault flag.

Driver-supply undervoltage forces both gates off and raises the fault flag. When it clears, switching resumes with no further action. A bootstrap undervoltage seen when the command rises withholds the high side. How the high side re-arms depends on the switch-node level at that moment. When the node was high, clearing the undervoltage is enough. When it was low, the command must also fall and rise again.

After each commanded turn-on, a cycle counter for that direction waits for the switch node to arrive at the matching rail. If the node does not arrive in time, the block latches a short-circuit fault. That latch overrides everything until the enable line rises. All outputs are registered, so each decision appears one clock after the inputs that caused it.

Top module: `gfs_fault_sup`

## Requirements
- R1: While reset is asserted and until it is released, hs_permit and ls_permit are 0, force_off is 1 and fault is 0.
- R2: While supply_ok is 0, both permits are 0 and force_off is 1, but fault stays 0.
- R3: A cycle with drv_uv at 1 makes fault 1, force_off 1 and both permits 0 from the next clock edge.
- R4: When drv_uv returns to 0 and no short circuit is latched, fault and force_off return to 0 and the permits follow the command at the next edge. No other input needs to change.
- R5: With no fault, supply ready and en at 1, the outputs follow in_cmd one edge later: in_cmd 1 gives hs_permit 1 and ls_permit 0, and in_cmd 0 gives the reverse. With en at 0, both permits are 0, and fault is 0 unless another requirement raises it.
- R6: If boot_uv is 1 on the cycle in which in_cmd rises, hs_permit stays 0 from the next edge on.
- R7: In the case of R6, if sw_hi was 1 on that rising cycle, hs_permit becomes 1 on the edge at which boot_uv is first sampled 0, provided in_cmd is still 1.
- R8: In the case of R6, if sw_hi was 0 on that rising cycle, clearing boot_uv alone does not grant hs_permit. hs_permit returns only when in_cmd goes low and then rises again while boot_uv is 0.
- R9: Counting from the edge at which hs_permit becomes 1, sw_hi must be sampled 1 at one of the next HI_LIMIT edges (default 75 cycles, 300 ns at 250 MHz). Otherwise a short circuit is latched at edge HI_LIMIT. An arrival sampled at edge HI_LIMIT itself is still in time.
- R10: Counting from the edge at which ls_permit becomes 1, sw_lo must be sampled 1 at one of the next LO_LIMIT edges (default 50 cycles, 200 ns at 250 MHz). Otherwise a short circuit is latched at edge LO_LIMIT.
- R11: A latched short circuit holds fault 1, force_off 1 and both permits 0. Undervoltage recovery does not clear it. Only a cycle with en at 1 after a cycle with en at 0 clears it, and on that same edge the permits follow the command again.
- R12: fault is the OR of the driver-supply undervoltage and the latched short circuit. hs_permit and ls_permit are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| supply_ok | input | 1 | Driver supply has reached its working level |
| drv_uv | input | 1 | Driver supply undervoltage flag |
| boot_uv | input | 1 | Bootstrap supply undervoltage flag |
| sw_hi | input | 1 | Switch node has reached the upper rail |
| sw_lo | input | 1 | Switch node has reached ground |
| in_cmd | input | 1 | Switching command: 1 asks for high side, 0 for low side |
| en | input | 1 | Enable; a rising edge clears a latched short circuit |
| hs_permit | output | 1 | High-side gate may be driven |
| ls_permit | output | 1 | Low-side gate may be driven |
| force_off | output | 1 | Both gates forced off by a supply or short-circuit condition |
| fault | output | 1 | Fault flag |

## Verification
A bootstrap re-arm state stuck in a waiting state shows as hs_permit held at 0 one edge after a clean command rise. A re-arm state released too early shows as hs_permit at 1 one edge after boot_uv clears with the node low. A transition counter off by one moves the rise of fault by one edge around the limit. The bench therefore checks the edge just before the limit and the edge at the limit, and it also feeds a rail arrival on the very last allowed edge. A latch that clears on the wrong event shows at once: fault drops during undervoltage recovery or on an enable that did not rise.

// File: rtl/gfs_pkg.sv
package gfs_pkg;

  // Bootstrap re-arm states
  typedef enum logic [1:0] {
    BA_IDLE     = 2'd0,
    BA_WAIT_UV  = 2'd1,
    BA_WAIT_TGL = 2'd2
  } boot_arm_t;

  // Switching directions watched by the transition timers
  localparam int unsigned NUM_DIR = 2;
  localparam int unsigned DIR_HI  = 0;
  localparam int unsigned DIR_LO  = 1;

endpackage

// File: rtl/gfs_edge_det.sv
module gfs_edge_det #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig,
  output logic [W-1:0] rise
);

  logic [W-1:0] sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q <= '0;
    end else begin
      sig_q <= sig;
    end
  end

  assign rise = sig & ~sig_q;

endmodule

// File: rtl/gfs_boot_arm.sv
module gfs_boot_arm
  import gfs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      in_rise,
  input  logic      boot_uv,
  input  logic      sw_hi,
  output logic      hs_allow_d,
  output boot_arm_t state_q
);

  boot_arm_t state_d;
  boot_arm_t blocked_mode;

  // Which wait applies is decided by the node level on the rising cycle
  assign blocked_mode = sw_hi ? BA_WAIT_UV : BA_WAIT_TGL;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      BA_IDLE: begin
        if (in_rise && boot_uv) state_d = blocked_mode;
      end
      BA_WAIT_UV: begin
        if (!boot_uv) state_d = BA_IDLE;
      end
      BA_WAIT_TGL: begin
        if (in_rise) begin
          state_d = boot_uv ? blocked_mode : BA_IDLE;
        end
      end
      default: state_d = BA_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BA_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign hs_allow_d = (state_d == BA_IDLE);

endmodule

// File: rtl/gfs_sc_timer.sv
module gfs_sc_timer #(
  parameter int unsigned LIMIT = 75
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  input  logic arrived,
  output logic expire
);

  localparam int unsigned CW   = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam int unsigned LAST = (LIMIT > 0) ? LIMIT - 1 : 0;

  logic          armed_q, armed_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          at_last;

  assign at_last = (cnt_q == CW'(LAST));
  assign expire  = armed_q && active && !arrived && at_last;

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    if (start) begin
      armed_d = 1'b1;
      cnt_d   = '0;
      cnt_en  = 1'b1;
    end else if (armed_q) begin
      if (!active || arrived || at_last) begin
        armed_d = 1'b0;
      end else begin
        cnt_d  = cnt_q + 1'b1;
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/gfs_fault_sup.sv
module gfs_fault_sup
  import gfs_pkg::*;
#(
  parameter int unsigned HI_LIMIT    = 75,
  parameter int unsigned LO_LIMIT    = 50,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic drv_uv,
  input  logic boot_uv,
  input  logic sw_hi,
  input  logic sw_lo,
  input  logic in_cmd,
  input  logic en,
  output logic hs_permit,
  output logic ls_permit,
  output logic force_off,
  output logic fault
);

  localparam int unsigned SS = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  // Reset: asserted asynchronously, released through a flop chain
  logic [SS-1:0] rst_pipe;
  logic          rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SS-2:0], 1'b1};
    end
  end

  assign rst_s_n = rst_pipe[SS-1];

  // Command and enable edges
  logic [1:0] rises;
  logic       in_rise, en_rise;

  gfs_edge_det #(.W(2)) u_edge (
    .clk   (clk),
    .rst_n (rst_s_n),
    .sig   ({en, in_cmd}),
    .rise  (rises)
  );

  assign in_rise = rises[0];
  assign en_rise = rises[1];

  // Bootstrap re-arm control
  logic      hs_allow_d;
  boot_arm_t boot_state;

  gfs_boot_arm u_boot (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .in_rise    (in_rise),
    .boot_uv    (boot_uv),
    .sw_hi      (sw_hi),
    .hs_allow_d (hs_allow_d),
    .state_q    (boot_state)
  );

  // Permit next-state and register
  logic [NUM_DIR-1:0] permit_d, permit_q;
  logic [NUM_DIR-1:0] node_at_rail;
  logic [NUM_DIR-1:0] expire;
  logic               sc_d, sc_q;
  logic               stop_d;
  logic               force_d, fault_d;

  assign node_at_rail[DIR_HI] = sw_hi;
  assign node_at_rail[DIR_LO] = sw_lo;

  // Transition timers, one per direction
  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    localparam int unsigned LIM = (d == DIR_HI) ? HI_LIMIT : LO_LIMIT;
    logic start_d;
    assign start_d = permit_d[d] & ~permit_q[d];
    gfs_sc_timer #(.LIMIT(LIM)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_s_n),
      .start   (start_d),
      .active  (permit_q[d]),
      .arrived (node_at_rail[d]),
      .expire  (expire[d])
    );
  end

  // Short-circuit latch: a new expiry wins over an enable edge
  assign sc_d = (|expire) | (sc_q & ~en_rise);

  always_comb begin
    stop_d           = ~supply_ok | drv_uv | sc_d;
    permit_d[DIR_HI] = en & in_cmd & ~stop_d & hs_allow_d;
    permit_d[DIR_LO] = en & ~in_cmd & ~stop_d;
    force_d          = stop_d;
    fault_d          = drv_uv | sc_d;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      sc_q      <= 1'b0;
      permit_q  <= '0;
      force_off <= 1'b1;
      fault     <= 1'b0;
    end else begin
      sc_q      <= sc_d;
      permit_q  <= permit_d;
      force_off <= force_d;
      fault     <= fault_d;
    end
  end

  assign hs_permit = permit_q[DIR_HI];
  assign ls_permit = permit_q[DIR_LO];

endmodule

// File: rtl/gfs_fault_sup_chk.sv
module gfs_fault_sup_chk (
  input logic clk,
  input logic rst_n,
  input logic in_cmd,
  input logic en,
  input logic drv_uv,
  input logic boot_uv,
  input logic hs_permit,
  input logic ls_permit,
  input logic force_off,
  input logic fault,
  input logic sc_q
);

  logic in_p, en_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_p <= 1'b0;
      en_p <= 1'b0;
    end else begin
      in_p <= in_cmd;
      en_p <= en;
    end
  end

  // R3
  uv_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv_uv |=> (fault && force_off && !hs_permit && !ls_permit));

  // R12
  no_both_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_permit && ls_permit));

  // R11
  sc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_q && !(en && !en_p)) |=> sc_q);

  // R11
  sc_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_q |-> (fault && force_off && !hs_permit && !ls_permit));

  // R6
  boot_withhold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cmd && !in_p && boot_uv) |=> !hs_permit);

  // R5
  permit_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_permit || ls_permit) |-> (!force_off && !fault));

endmodule

bind gfs_fault_sup gfs_fault_sup_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_s_n),
  .in_cmd    (in_cmd),
  .en        (en),
  .drv_uv    (drv_uv),
  .boot_uv   (boot_uv),
  .hs_permit (hs_permit),
  .ls_permit (ls_permit),
  .force_off (force_off),
  .fault     (fault),
  .sc_q      (sc_q)
);

// File: tb/gfs_fault_sup_bench.sv
`timescale 1ns/1ps
module gfs_fault_sup_bench;

  localparam int HI_LIM = 75;
  localparam int LO_LIM = 50;
  localparam int NVEC   = 10;

  // Vector bits: sup uv boot hi lo in en | hs ls fo fault
  localparam logic [10:0] VEC [NVEC] = '{
    11'b0000101_0010,
    11'b1000101_0100,
    11'b1001011_1000,
    11'b1000101_0100,
    11'b1100101_0011,
    11'b1101011_0011,
    11'b1001011_1000,
    11'b1001010_0000,
    11'b1001011_1000,
    11'b1000101_0100
  };

  logic clk, rst_n;
  logic supply_ok, drv_uv, boot_uv, sw_hi, sw_lo, in_cmd, en;
  logic hs_permit, ls_permit, force_off, fault;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  gfs_fault_sup #(.HI_LIMIT(HI_LIM), .LO_LIMIT(LO_LIM)) u_gfs_fault_sup (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .drv_uv    (drv_uv),
    .boot_uv   (boot_uv),
    .sw_hi     (sw_hi),
    .sw_lo     (sw_lo),
    .in_cmd    (in_cmd),
    .en        (en),
    .hs_permit (hs_permit),
    .ls_permit (ls_permit),
    .force_off (force_off),
    .fault     (fault)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic string row_tag(int i);
    case (i)
      0:       return "R2 supply not ready";
      4, 5:    return "R3 driver undervoltage";
      6:       return "R4 undervoltage recovery";
      7:       return "R5 enable low";
      default: return "R5 normal switching";
    endcase
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic go_low();
    in_cmd = 1'b0; sw_lo = 1'b1; sw_hi = 1'b0;
    step(); step();
  endtask

  task automatic en_pulse();
    en = 1'b0; step();
    en = 1'b1; step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    supply_ok = 1'b0; drv_uv = 1'b0; boot_uv = 1'b0;
    sw_hi = 1'b0; sw_lo = 1'b1; in_cmd = 1'b0; en = 1'b1;
    repeat (3) step();
    // R1 reset state
    chk("R1 hs_permit in reset", hs_permit, 1'b0);
    chk("R1 ls_permit in reset", ls_permit, 1'b0);
    chk("R1 force_off in reset", force_off, 1'b1);
    chk("R1 fault in reset", fault, 1'b0);
    rst_n = 1'b1;
    repeat (3) step();

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      supply_ok = VEC[i][10]; drv_uv = VEC[i][9]; boot_uv = VEC[i][8];
      sw_hi = VEC[i][7]; sw_lo = VEC[i][6]; in_cmd = VEC[i][5]; en = VEC[i][4];
      step();
      chk($sformatf("%s row %0d hs", row_tag(i), i), hs_permit, VEC[i][3]);
      chk($sformatf("%s row %0d ls", row_tag(i), i), ls_permit, VEC[i][2]);
      chk($sformatf("%s row %0d force", row_tag(i), i), force_off, VEC[i][1]);
      chk($sformatf("%s row %0d fault", row_tag(i), i), fault, VEC[i][0]);
    end

    // R6 / R7: bootstrap low with node high
    go_low();
    boot_uv = 1'b1; in_cmd = 1'b1; sw_hi = 1'b1; sw_lo = 1'b0;
    step();
    chk("R6 hs withheld", hs_permit, 1'b0);
    step();
    chk("R6 hs still withheld", hs_permit, 1'b0);
    boot_uv = 1'b0;
    step();
    chk("R7 hs granted on boot clear", hs_permit, 1'b1);

    // R8: bootstrap low with node low
    go_low();
    boot_uv = 1'b1; in_cmd = 1'b1; sw_hi = 1'b0; sw_lo = 1'b0;
    step();
    chk("R6 hs withheld node low", hs_permit, 1'b0);
    boot_uv = 1'b0;
    step(); step();
    chk("R8 boot clear alone not enough", hs_permit, 1'b0);
    in_cmd = 1'b0; sw_lo = 1'b1;
    step();
    chk("R8 ls during toggle", ls_permit, 1'b1);
    in_cmd = 1'b1; sw_hi = 1'b1; sw_lo = 1'b0;
    step();
    chk("R8 hs after toggle", hs_permit, 1'b1);

    // R9 boundary: arrival on the last allowed edge
    go_low();
    in_cmd = 1'b1; sw_hi = 1'b0; sw_lo = 1'b0;
    step();
    chk("R9 hs rises", hs_permit, 1'b1);
    repeat (HI_LIM - 1) step();
    sw_hi = 1'b1;
    step();
    chk("R9 late arrival in time", fault, 1'b0);
    chk("R9 hs kept", hs_permit, 1'b1);

    // R9 timeout
    go_low();
    in_cmd = 1'b1; sw_hi = 1'b0; sw_lo = 1'b0;
    step();
    repeat (HI_LIM - 1) step();
    chk("R9 no fault before limit", fault, 1'b0);
    step();
    chk("R9 fault at limit", fault, 1'b1);
    chk("R9 hs off at limit", hs_permit, 1'b0);
    chk("R9 force_off at limit", force_off, 1'b1);

    // R11: latch holds through recovery, clears on enable rise
    in_cmd = 1'b0; sw_lo = 1'b1;
    step(); step(); step();
    chk("R11 fault latched", fault, 1'b1);
    chk("R11 ls held off", ls_permit, 1'b0);
    drv_uv = 1'b1; step();
    drv_uv = 1'b0; step(); step();
    chk("R11 latch beats uv recovery", fault, 1'b1);
    en = 1'b0; step();
    chk("R11 en low keeps latch", fault, 1'b1);
    en = 1'b1; step();
    chk("R11 cleared by en rise", fault, 1'b0);
    chk("R11 ls resumes", ls_permit, 1'b1);

    // R10 timeout
    in_cmd = 1'b1; sw_hi = 1'b1; sw_lo = 1'b0;
    step(); step();
    chk("R10 hs before low turn", hs_permit, 1'b1);
    in_cmd = 1'b0; sw_hi = 1'b0; sw_lo = 1'b0;
    step();
    chk("R10 ls rises", ls_permit, 1'b1);
    repeat (LO_LIM - 1) step();
    chk("R10 no fault before limit", fault, 1'b0);
    step();
    chk("R10 fault at limit", fault, 1'b1);
    chk("R10 ls off at limit", ls_permit, 1'b0);
    sw_lo = 1'b1;
    en_pulse();
    chk("R12 fault clear after en rise", fault, 1'b0);
    chk("R12 only one permit", hs_permit & ls_permit, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule